// File: doc/BRIEF.md
# I2C SCL Clock Divider

This block turns the peripheral clock into the timing base for an I2C controller. A prescaler produces an internal-clock enable at the peripheral clock divided by one plus a small prescale field. On top of that enable, a period counter lays out each SCL period as a low phase followed by a high phase. The period length in internal ticks is a fixed base of twenty ticks, plus eight ticks per step of a six-bit period field, plus a four-bit compensation count for rise time, fall time and internal delay.

Both fields arrive in one packed divider word. The prescale field sits in the low bits and its width is a parameter of two or three. The period field sits directly above it. The divider word and the compensation count are captured together at each SCL period boundary. A change written in the middle of a period therefore never produces a malformed period.

A one-shot timer gives the controller a delay between driving SDA and the first SCL edge of a transfer. The delay is counted in internal ticks. The host computes the field values; this block only applies them.

Top module: `scl_clkgen`

## Requirements
- R1: While reset is held and on the first clock after it is released, `scl_low` is 1, `period_end` is 0 and `setup_done` is 0.
- R2: `ick_en` is high for exactly one clock in every (1 + CDF) clocks. With CDF equal to 0 it is high on every clock.
- R3: One SCL period lasts P = 20 + 8·SCGD + COMP internal ticks, which is P·(1 + CDF) peripheral clocks.
- R4: Each period starts with a low phase of ceil(P/2) ticks (`scl_low` = 1), and the remaining floor(P/2) ticks are high.
- R5: In `div_cfg`, bits [CDF_W-1:0] carry CDF and bits [CDF_W+5:CDF_W] carry SCGD. Every combination of the two fields, including both at their maximum, yields the period of R3.
- R6: A change on `div_cfg` or `comp_cnt` during a period does not alter that period. The new values govern from the following period on.
- R7: A `setup_go` pulse with `setup_code` equal to 4'hF raises `setup_done` after 17 internal ticks have elapsed.
- R8: A `setup_go` pulse with any other `setup_code` value, including the nominal 4'h4, raises `setup_done` after 6 internal ticks.
- R9: `period_end` is high for exactly one clock at the end of each period, namely the last clock of the period's final tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| div_cfg | input | CDF_W+6 | Packed divider word: SCGD above CDF |
| comp_cnt | input | 4 | Rise/fall/internal-delay compensation ticks |
| setup_go | input | 1 | Starts the first-bit setup delay |
| setup_code | input | 4 | Setup delay select (4'hF long, else short) |
| ick_en | output | 1 | Internal clock enable |
| scl_low | output | 1 | 1 during the SCL low phase |
| period_end | output | 1 | Pulse on the last clock of each SCL period |
| setup_done | output | 1 | Pulse when the setup delay has elapsed |

## Verification
Each divider setting is measured over one whole period, counting clocks, low-phase clocks and ticks. This separates the prescale factor from the tick count and from the low/high split.

Directed settings cover the following cases:
- CDF of zero, which gives a continuous enable.
- Both fields at maximum, and odd and even period lengths, which exercise the round-up of the low phase.
- A divider change made mid-period, which must leave that period at its old length.

Random field combinations then exercise the packing. Setup delays are timed with the long code, the nominal short code and an unlisted code, under a prescaler that is not one.

// File: rtl/scl_div_pkg.sv
package scl_div_pkg;

    localparam int BASE_TICKS      = 20;
    localparam int SCGD_STEP       = 8;
    localparam int SETUP_SHORT_TK  = 6;
    localparam int SETUP_LONG_TK   = 17;
    localparam logic [3:0] SETUP_LONG_CODE = 4'hF;

    typedef enum logic {
        SU_SHORT = 1'b0,
        SU_LONG  = 1'b1
    } setup_mode_e;

    typedef struct packed {
        logic busy;
        logic [4:0] left;
    } setup_state_t;

    function automatic int period_ticks(input int scgd, input int comp);
        return BASE_TICKS + SCGD_STEP * scgd + comp;
    endfunction

    function automatic int setup_ticks(input setup_mode_e m);
        return (m == SU_LONG) ? SETUP_LONG_TK : SETUP_SHORT_TK;
    endfunction

    function automatic setup_mode_e decode_setup(input logic [3:0] code);
        return (code == SETUP_LONG_CODE) ? SU_LONG : SU_SHORT;
    endfunction

endpackage

// File: rtl/scl_prescale.sv
module scl_prescale #(
    parameter int CDF_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CDF_W-1:0] cdf,
    output logic             tick
);
    logic [CDF_W-1:0] pcnt;

    assign tick = (pcnt >= cdf);

    always_ff @(posedge clk) begin
        if (rst || tick) pcnt <= '0;
        else             pcnt <= pcnt + CDF_W'(1);
    end

    AST_PCNT_RANGE: assert property (@(posedge clk) disable iff (rst)
        pcnt <= cdf) else $error("prescale count beyond limit"); // R2
    AST_TICK_GAP: assert property (@(posedge clk) disable iff (rst)
        (tick && cdf != '0) |=> (!tick || cdf == '0)) else $error("back-to-back ticks"); // R2
endmodule

// File: rtl/scl_phase_gen.sv
module scl_phase_gen
    import scl_div_pkg::*;
#(
    parameter int SCGD_W = 6,
    parameter int COMP_W = 4,
    parameter int PER_W  = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic [SCGD_W-1:0] scgd,
    input  logic [COMP_W-1:0] comp,
    output logic              scl_low,
    output logic              wrap
);
    logic [PER_W-1:0] per;
    logic [PER_W-1:0] low_len;
    logic [PER_W-1:0] cnt;

    assign per     = PER_W'(period_ticks(int'(scgd), int'(comp)));
    assign low_len = (per + PER_W'(1)) >> 1;
    assign wrap    = tick && (cnt == per - PER_W'(1));
    assign scl_low = (cnt < low_len);

    always_ff @(posedge clk) begin
        if (rst || wrap) cnt <= '0;
        else if (tick)   cnt <= cnt + PER_W'(1);
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt < per) else $error("period counter overran"); // R3
    AST_LOW_AFTER_WRAP: assert property (@(posedge clk) disable iff (rst)
        wrap |=> scl_low) else $error("period did not start low"); // R4
    AST_HIGH_AT_END: assert property (@(posedge clk) disable iff (rst)
        wrap |-> !scl_low) else $error("period ended in low phase"); // R4
endmodule

// File: rtl/scl_setup_timer.sv
module scl_setup_timer
    import scl_div_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       go,
    input  logic [3:0] code,
    output logic       done
);
    setup_state_t st;
    setup_mode_e  mode;

    assign mode = decode_setup(code);

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= '0;
            done <= 1'b0;
        end else begin
            done <= st.busy && tick && (st.left == 5'd1);
            if (go && !st.busy) begin
                st.busy <= 1'b1;
                st.left <= 5'(setup_ticks(mode));
            end else if (st.busy && tick) begin
                st.left <= st.left - 5'd1;
                if (st.left == 5'd1) st.busy <= 1'b0;
            end
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done) else $error("setup done held"); // R7
    AST_LEFT_NONZERO: assert property (@(posedge clk) disable iff (rst)
        st.busy |-> st.left != 5'd0) else $error("busy with nothing left"); // R8
endmodule

// File: rtl/scl_clkgen.sv
module scl_clkgen
    import scl_div_pkg::*;
#(
    parameter int CDF_W  = 3,
    parameter int SCGD_W = 6,
    parameter int COMP_W = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [CDF_W+SCGD_W-1:0] div_cfg,
    input  logic [COMP_W-1:0]       comp_cnt,
    input  logic                    setup_go,
    input  logic [3:0]              setup_code,
    output logic                    ick_en,
    output logic                    scl_low,
    output logic                    period_end,
    output logic                    setup_done
);
    localparam int DIV_W   = CDF_W + SCGD_W;
    localparam int PER_MAX = BASE_TICKS + SCGD_STEP * (2**SCGD_W - 1) + 2**COMP_W - 1;
    localparam int PER_W   = $clog2(PER_MAX + 2);

    logic [DIV_W-1:0]  cfg_q;
    logic [COMP_W-1:0] comp_q;
    logic [CDF_W-1:0]  cdf_f;
    logic [SCGD_W-1:0] scgd_f;

    assign cdf_f  = cfg_q[CDF_W-1:0];
    assign scgd_f = cfg_q[CDF_W +: SCGD_W];

    always_ff @(posedge clk) begin
        if (rst || period_end) begin
            cfg_q  <= div_cfg;
            comp_q <= comp_cnt;
        end
    end

    scl_prescale #(.CDF_W(CDF_W)) u_pre (
        .clk  (clk),
        .rst  (rst),
        .cdf  (cdf_f),
        .tick (ick_en)
    );

    scl_phase_gen #(.SCGD_W(SCGD_W), .COMP_W(COMP_W), .PER_W(PER_W)) u_phase (
        .clk     (clk),
        .rst     (rst),
        .tick    (ick_en),
        .scgd    (scgd_f),
        .comp    (comp_q),
        .scl_low (scl_low),
        .wrap    (period_end)
    );

    scl_setup_timer u_setup (
        .clk  (clk),
        .rst  (rst),
        .tick (ick_en),
        .go   (setup_go),
        .code (setup_code),
        .done (setup_done)
    );

    AST_CFG_STABLE: assert property (@(posedge clk) disable iff (rst)
        !period_end |=> ($stable(cfg_q) && $stable(comp_q))) else $error("divider moved mid-period"); // R6
    AST_END_PULSE: assert property (@(posedge clk) disable iff (rst)
        period_end |=> !period_end) else $error("period end held"); // R9
    AST_END_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        period_end |-> ick_en) else $error("period end without tick"); // R9
endmodule

// File: tb/scl_clkgen_tb.sv
module scl_clkgen_tb;
    localparam int CLK_PERIOD = 10;
    localparam int CDF_W      = 3;
    localparam int SCGD_W     = 6;
    localparam int DIV_W      = CDF_W + SCGD_W;
    localparam int WATCHDOG   = 190000;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [DIV_W-1:0] div_cfg = '0;
    logic [3:0]       comp_cnt = '0;
    logic             setup_go = 1'b0;
    logic [3:0]       setup_code = 4'h4;
    logic             ick_en, scl_low, period_end, setup_done;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    scl_clkgen #(.CDF_W(CDF_W), .SCGD_W(SCGD_W), .COMP_W(4)) u_dut (
        .clk        (clk),
        .rst        (rst),
        .div_cfg    (div_cfg),
        .comp_cnt   (comp_cnt),
        .setup_go   (setup_go),
        .setup_code (setup_code),
        .ick_en     (ick_en),
        .scl_low    (scl_low),
        .period_end (period_end),
        .setup_done (setup_done)
    );

    function automatic int exp_period(input int scgd, input int comp);
        return 20 + 8 * scgd + comp;
    endfunction

    function automatic logic [DIV_W-1:0] pack(input int cdf, input int scgd);
        return {SCGD_W'(scgd), CDF_W'(cdf)};
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_pend();
        do @(negedge clk); while (!period_end);
    endtask

    // Counts one period starting right after a period_end sample.
    task automatic measure(input int chg_at, input logic [DIV_W-1:0] ncfg,
                           input logic [3:0] ncomp,
                           output int clks, output int lows, output int ticks);
        clks = 0; lows = 0; ticks = 0;
        forever begin
            @(negedge clk);
            clks++;
            lows  += int'(scl_low);
            ticks += int'(ick_en);
            if (clks == chg_at) begin
                div_cfg  = ncfg;
                comp_cnt = ncomp;
            end
            if (period_end) break;
        end
    endtask

    task automatic run_cfg(input string tag, input int cdf, input int scgd, input int comp);
        int c, l, t, p;
        div_cfg  = pack(cdf, scgd);
        comp_cnt = 4'(comp);
        wait_pend();
        wait_pend();
        measure(-1, div_cfg, comp_cnt, c, l, t);
        p = exp_period(scgd, comp);
        check({tag, " R3 ticks"}, t, p);
        check({tag, " R2 clocks"}, c, p * (cdf + 1));
        check({tag, " R4 low clocks"}, l, ((p + 1) / 2) * (cdf + 1));
        @(negedge clk);
        check({tag, " R9 single pulse"}, int'(period_end), 0);
    endtask

    task automatic run_setup(input string tag, input logic [3:0] code, input int exp);
        int n = 0;
        int guard = 0;
        setup_code = code;
        setup_go = 1'b1;
        forever begin
            @(negedge clk);
            setup_go = 1'b0;
            if (setup_done || guard > 2000) break;
            n += int'(ick_en);
            guard++;
        end
        check(tag, n, exp);
        @(negedge clk);
        check({tag, " pulse"}, int'(setup_done), 0);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int c, l, t;
        void'($urandom(32'h5EED));
        div_cfg = pack(1, 0);
        repeat (4) @(negedge clk);
        check("R1 scl_low in reset", int'(scl_low), 1);
        check("R1 period_end in reset", int'(period_end), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 scl_low after reset", int'(scl_low), 1);
        check("R1 period_end after reset", int'(period_end), 0);
        check("R1 setup_done after reset", int'(setup_done), 0);

        run_cfg("cdf0 R2", 0, 0, 0);
        run_cfg("odd period R4", 1, 2, 3);
        run_cfg("max fields R5", 7, 63, 15);
        run_cfg("cdf only R5", 7, 0, 0);
        run_cfg("scgd only R5", 0, 63, 0);
        run_cfg("mixed R5", 2, 5, 1);

        // R6: change mid-period, old values must finish the period
        div_cfg = pack(1, 1); comp_cnt = 4'd2;
        wait_pend(); wait_pend();
        measure(3, pack(3, 4), 4'd5, c, l, t);
        check("R6 old period ticks", t, exp_period(1, 2));
        check("R6 old period clocks", c, exp_period(1, 2) * 2);
        measure(-1, div_cfg, comp_cnt, c, l, t);
        check("R6 new period ticks", t, exp_period(4, 5));
        check("R6 new period clocks", c, exp_period(4, 5) * 4);

        for (int i = 0; i < 8; i++) begin
            int rc = int'($urandom % 4);
            int rs = int'($urandom % 64);
            int rp = int'($urandom % 16);
            run_cfg("random R5", rc, rs, rp);
        end

        div_cfg = pack(2, 0); comp_cnt = 4'd0;
        wait_pend(); wait_pend();
        run_setup("R7 long code", 4'hF, 17);
        run_setup("R8 nominal short code", 4'h4, 6);
        run_setup("R8 other code", 4'h0, 6);
        run_setup("R8 code 0xE", 4'hE, 6);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule